// File: doc/BRIEF.md
# Split-Band Hysteresis Gate Controller

This block produces the two gate commands for one half-bridge leg of a current-controlled inverter. It works from a sampled current setpoint, a sampled measured current and a programmable band half-width. All three are 16-bit two's complement values. A mode input chooses between two control schemes.

In the classic scheme, one hysteresis comparator keeps the current inside a band around the setpoint, and the low-side command is the complement of the high-side command. In the split scheme, each switch has its own set/reset latch. The high side closes the lower half of the band and the low side closes the upper half. A switch is therefore never commanded on while the current free-wheels through the opposite diode, and both switches rest off around a current zero crossing. Comparisons happen only on an external sample strobe, nominally at 50 kHz. Every turn-on is held back by a programmable dead time, counted in clock cycles, after the most recent turn-off. A three-phase inverter uses three instances.

Top module: `split_hyst_leg`

## Requirements
- R1: After reset, `gate_hi`, `gate_lo` and `fault` are all 0.
- R2: Classic mode (`split_mode`=0), on a strobe: the high-side request becomes 1 if meas <= ref - band. It becomes 0 if meas >= ref + band; the first test wins when both hold. Otherwise it keeps its value.
- R3: In classic mode, after a strobe the low-side request is the complement of the high-side request.
- R4: Split mode (`split_mode`=1), on a strobe: the high-side latch sets if meas <= ref - band. Otherwise it clears if meas >= ref. Otherwise it holds.
- R5: Split mode, on a strobe: the low-side latch sets if meas >= ref + band. Otherwise it clears if meas <= ref. Otherwise it holds.
- R6: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R7: Thresholds are formed with one extra bit, so ref ± band never wraps, including at the extreme 16-bit values.
- R8: If a strobe would leave both requests at 1, both requests are cleared instead and `fault` is set. `fault` stays 1 until reset.
- R9: A gate whose request is pending rises D+1 clock edges after the most recent gate fall, where D is the dead-time count. In classic mode, a request swap at strobe edge S therefore shows the new gate high after edge S+D+2. A request that arrives once the count has expired shows its gate after the next edge.
- R10: The dead-time count resets to ceil(CLK_KHZ*33/10000) cycles, which is 330 at the default 100 MHz. A clock with `dt_load`=1 replaces it with `dt_value`.
- R11: Setpoint, measurement, band and mode are examined only in cycles where `sample` is 1. Changes between strobes leave the gates unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 1 | One-cycle comparison strobe |
| split_mode | input | 1 | 0 = classic complementary, 1 = split latches |
| dt_load | input | 1 | Load `dt_value` into the dead-time count |
| dt_value | input | DTW (12) | New dead-time count in clock cycles |
| i_ref | input | W (16) | Current setpoint, signed |
| i_meas | input | W (16) | Measured current, signed |
| band | input | W (16) | Band half-width, signed, should be positive |
| gate_hi | output | 1 | High-side switch command |
| gate_lo | output | 1 | Low-side switch command |
| fault | output | 1 | Sticky flag for a simultaneous on request |

## Verification
The measurement is ramped up and then back down across the band, with stops on each threshold and on the setpoint, for several setpoints and band widths in both modes. The rising ramp separates set thresholds from clear thresholds. The falling ramp exposes wrong hold behaviour and wrong inclusive/exclusive compares. Setpoints and bands at the extreme signed values show whether the threshold sums wrap. A zero band with the measurement equal to the setpoint provokes the clash fault. Timed swaps under the reset dead time and under a loaded one pin down the exact turn-on edge. Measurement changes without a strobe show that the gates ignore off-strobe inputs.

// File: rtl/split_hyst_leg.sv
module split_hyst_leg #(
  parameter int W       = 16,
  parameter int DTW     = 12,
  parameter int CLK_KHZ = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic                split_mode,
  input  logic                dt_load,
  input  logic [DTW-1:0]      dt_value,
  input  logic signed [W-1:0] i_ref,
  input  logic signed [W-1:0] i_meas,
  input  logic signed [W-1:0] band,
  output logic                gate_hi,
  output logic                gate_lo,
  output logic                fault
);

  localparam int             DT_CYC = (CLK_KHZ * 33 + 9999) / 10000;
  localparam logic [DTW-1:0] DT_RST = DT_CYC[DTW-1:0];

  logic signed [W:0] ref_x, meas_x, band_x, lo_th, hi_th;
  logic at_lo, at_hi, above_ref, below_ref;
  logic req_hi, req_lo;
  logic c_hi, s_hi, s_lo, n_hi, n_lo, clash;
  logic [DTW-1:0] dt, cnt;

  assign ref_x  = {i_ref[W-1], i_ref};
  assign meas_x = {i_meas[W-1], i_meas};
  assign band_x = {band[W-1], band};
  assign lo_th  = ref_x - band_x;
  assign hi_th  = ref_x + band_x;

  assign at_lo     = meas_x <= lo_th;
  assign at_hi     = meas_x >= hi_th;
  assign above_ref = meas_x >= ref_x;
  assign below_ref = meas_x <= ref_x;

  always_comb begin
    c_hi = req_hi;
    if (at_lo)      c_hi = 1'b1;
    else if (at_hi) c_hi = 1'b0;
    s_hi = req_hi;
    if (at_lo)          s_hi = 1'b1;
    else if (above_ref) s_hi = 1'b0;
    s_lo = req_lo;
    if (at_hi)          s_lo = 1'b1;
    else if (below_ref) s_lo = 1'b0;
    n_hi = split_mode ? s_hi : c_hi;
    n_lo = split_mode ? s_lo : !c_hi;
  end

  assign clash = n_hi & n_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_hi <= 1'b0;
      req_lo <= 1'b0;
      fault  <= 1'b0;
    end else if (sample) begin
      req_hi <= n_hi & !clash;
      req_lo <= n_lo & !clash;
      if (clash) fault <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dt      <= DT_RST;
      cnt     <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      if (dt_load) dt <= dt_value;
      if ((gate_hi && !req_hi) || (gate_lo && !req_lo)) begin
        cnt     <= dt;
        gate_hi <= gate_hi & req_hi;
        gate_lo <= gate_lo & req_lo;
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        if (!gate_hi && !gate_lo && cnt == '0) begin
          gate_hi <= req_hi & !req_lo;
          gate_lo <= req_lo & !req_hi;
        end
      end
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_classic_compl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !split_mode) |=> (req_lo != req_hi));

  assert_hi_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hi |=> !gate_hi);

  assert_lo_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_lo |=> !gate_lo);

  assert_fall_blocks_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_lo) |-> !gate_hi);

endmodule

// File: tb/test_split_hyst_leg.sv
module test_split_hyst_leg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DTW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0;
  logic split_mode = 1'b0;
  logic dt_load = 1'b0;
  logic [DTW-1:0] dt_value = '0;
  logic signed [W-1:0] i_ref = '0, i_meas = '0, band = '0;
  logic gate_hi, gate_lo, fault;

  int errors = 0;
  int checks = 0;
  int mh = 0, ml = 0, mf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_hyst_leg #(.W(W), .DTW(DTW), .CLK_KHZ(100000)) i_split_hyst_leg (
    .clk(clk), .rst_n(rst_n), .sample(sample), .split_mode(split_mode),
    .dt_load(dt_load), .dt_value(dt_value), .i_ref(i_ref), .i_meas(i_meas),
    .band(band), .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mh = 0; ml = 0; mf = 0;
  endtask

  task automatic load_dt(input int d);
    @(negedge clk); dt_value = DTW'(d); dt_load = 1'b1;
    @(negedge clk); dt_load = 1'b0;
  endtask

  task automatic pulse(input int r, input int m, input int b);
    int nh, nl;
    @(negedge clk);
    i_ref = W'(r); i_meas = W'(m); band = W'(b); sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
    nh = mh; nl = ml;
    if (split_mode) begin
      if (m <= r - b) nh = 1; else if (m >= r) nh = 0;
      if (m >= r + b) nl = 1; else if (m <= r) nl = 0;
    end else begin
      if (m <= r - b) nh = 1; else if (m >= r + b) nh = 0;
      nl = (nh == 0) ? 1 : 0;
    end
    if (nh == 1 && nl == 1) begin mh = 0; ml = 0; mf = 1; end
    else begin mh = nh; ml = nl; end
  endtask

  task automatic settle_check(input string thi, input string tlo);
    repeat (8) @(negedge clk);
    chk(thi, int'(gate_hi), mh);
    chk(tlo, int'(gate_lo), ml);
    chk("R8 fault", int'(fault), mf);
    chk("R6 overlap", int'(gate_hi && gate_lo), 0);
  endtask

  task automatic count_hi(output int n);
    n = 0;
    while (gate_hi !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic count_lo(output int n);
    n = 0;
    while (gate_lo !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk);
    chk("R1 gate_hi", int'(gate_hi), 0);
    chk("R1 gate_lo", int'(gate_lo), 0);
    chk("R1 fault", int'(fault), 0);

    // R10 reset dead time 330, R9 edge counts
    split_mode = 1'b0;
    pulse(0, -5, 3); count_hi(n); chk("R9 first turn-on", n, 1);
    pulse(0, 5, 3);  count_lo(n); chk("R10 reset dead time swap", n, 332);
    chk("R6 after swap", int'(gate_hi), 0);
    load_dt(2);
    pulse(0, -5, 3); count_hi(n); chk("R10 loaded dead time swap", n, 4);
    split_mode = 1'b1;
    pulse(0, 0, 3);
    repeat (10) @(negedge clk);
    chk("R4 rest off hi", int'(gate_hi), 0);
    chk("R5 rest off lo", int'(gate_lo), 0);
    pulse(0, -5, 3); count_hi(n); chk("R9 expired count", n, 1);

    // R11 no strobe, no effect
    @(negedge clk); i_meas = 16'sd10; i_ref = 16'sd0;
    repeat (10) @(negedge clk);
    chk("R11 hi held", int'(gate_hi), 1);
    chk("R11 lo held", int'(gate_lo), 0);
    split_mode = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 mode change held", int'(gate_lo), 0);

    // ramps in both modes
    for (int md = 0; md < 2; md++) begin
      split_mode = md[0];
      for (int ri = 0; ri < 3; ri++) begin
        int r, b;
        r = (ri == 0) ? 0 : (ri == 1) ? 100 : -50;
        b = (ri == 1) ? 1 : 3;
        for (int k = -6; k <= 6; k++) begin
          pulse(r, r + k, b);
          if (md == 0) settle_check("R2 classic hi", "R3 classic lo");
          else settle_check("R4 split hi", "R5 split lo");
        end
        for (int k = 6; k >= -6; k--) begin
          pulse(r, r + k, b);
          if (md == 0) settle_check("R2 classic hi", "R3 classic lo");
          else settle_check("R4 split hi", "R5 split lo");
        end
      end
    end

    // R7 extremes
    split_mode = 1'b1;
    pulse(0, 0, 3);
    pulse(32767, 32767, 32767);   settle_check("R7 hi top", "R7 lo top");
    pulse(-32768, -32768, 32767); settle_check("R7 hi bottom", "R7 lo bottom");
    pulse(32767, -32768, 32767);  settle_check("R7 hi set far", "R7 lo set far");
    pulse(-32768, 32767, 32767);  settle_check("R7 hi swap far", "R7 lo swap far");
    split_mode = 1'b0;
    pulse(32767, 32767, 32767);   settle_check("R7 classic hi", "R7 classic lo");
    pulse(-32768, -32768, 32767); settle_check("R7 classic hi b", "R7 classic lo b");

    // R8 clash fault
    do_reset();
    load_dt(2);
    split_mode = 1'b1;
    pulse(10, 10, 0);
    settle_check("R8 clash hi", "R8 clash lo");
    chk("R8 fault set", int'(fault), 1);
    pulse(10, 0, 3);
    settle_check("R8 after hi", "R8 after lo");
    chk("R8 fault sticky", int'(fault), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule